// File: doc/BRIEF.md
# Triple-Write Confirmed Frequency Select Register

This block is a single memory-mapped control register. It changes a reference-frequency selection only after software has written the same legal code three times in a row. It sits on a plain synchronous register bus. The bus has an address, separate write and read strobes, an 8-bit write data path and an 8-bit read data path. Any illegal code resets the write sequence. Any read or write to a different address between the writes also resets it. Downstream logic therefore never sees a selection that a stray or partial access produced.

A read of the register returns three fields. The top two bits hold the committed selection. The next two bits hold how many matching writes are in progress. The low nibble shows the pending code. Shortly after reset the register ignores writes for a hold-off window, which is set in clock cycles. When a setting commits, the block raises a one-cycle pulse next to the 2-bit selection, so that clock-select logic can act on it.

Top module: `triple_write_sel`

## Requirements
- R1: After reset the committed selection is 1, the progress count is 0, the pending nibble is 0 and the commit pulse is low.
- R2: Only the write codes 0x11, 0x22, 0x44 and 0x88 are legal. They map to selections 0, 1, 2 and 3 respectively. Every other byte is illegal.
- R3: A legal write whose selection differs from the pending one sets the count to 1. So does any legal write while the count is 0. In either case the pending nibble becomes one-hot, with bit N set for selection N.
- R4: A legal write that repeats the pending selection while the count is 1 raises the count to 2. The count never reads 3.
- R5: A legal write that repeats the pending selection while the count is 2 commits that selection and clears the count to 0. On the clock after that write, the commit pulse is high for exactly one cycle.
- R6: An illegal write to the register clears the count to 0 and leaves the committed selection unchanged.
- R7: A read or a write to any other address clears the count to 0.
- R8: A read of the register itself leaves the count and the pending selection unchanged.
- R9: Writes that arrive before HOLDOFF_CYCLES clock cycles have passed since reset release have no effect.
- R10: While the read strobe is high with the register address, read data is {selection[1:0], count[1:0], pending nibble[3:0]}. Bits 7:6 hold the selection, bits 5:4 the count and bits 3:0 the nibble. The nibble is 0 when the count is 0. Read data is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during a read of this register |
| sel_id | output | 2 | Committed frequency selection |
| sel_commit | output | 1 | One-cycle pulse when a new selection commits |

## Verification
The assertions assume three things about the bus:
- a single access per cycle;
- the write and read strobes are never high together;
- the address is stable while a strobe is high.

The bench drives each access for exactly one clock, with only one strobe high, and returns both strobes to low between accesses.

Every byte value goes through a three-write sequence. In-progress sequences are then interleaved with foreign reads and writes, with own reads, and with alternating legal codes. These cases reach every transition of the count.

// File: rtl/triple_write_pkg.sv
package triple_write_pkg;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned NUM_SEL = 1 << SEL_W;
  localparam int unsigned CNT_W   = 2;
  localparam int unsigned CONFIRM = 3;
  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam sel_t RESET_SEL = sel_t'(1);
endpackage

// File: rtl/triple_write_holdoff.sv
module triple_write_holdoff #(
  parameter int unsigned HOLDOFF_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  generate
    if (HOLDOFF_CYCLES == 0) begin : g_none
      assign ready = 1'b1;
    end else begin : g_count
      localparam int unsigned HW = $clog2(HOLDOFF_CYCLES + 1);
      localparam logic [HW-1:0] LIMIT = HW'(HOLDOFF_CYCLES);
      logic [HW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      assign ready  = (cnt_q == LIMIT);
      assign cnt_en = !ready;

      always_comb begin
        cnt_d = cnt_q;
        if (cnt_en) cnt_d = cnt_q + HW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assert_ready_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    end
  endgenerate
endmodule

// File: rtl/triple_write_decode.sv
module triple_write_decode
  import triple_write_pkg::*;
(
  input  logic [7:0] code,
  output logic       legal,
  output sel_t       sel
);
  logic [NUM_SEL-1:0] hit;

  generate
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_match
      localparam logic [3:0] NIB = 4'(1 << i);
      assign hit[i] = (code == {NIB, NIB});
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_SEL; i++)
      if (hit[i]) sel = sel_t'(i);
  end

  assign legal = |hit;

  always_comb begin
    assert_hit_onehot_R2: assert ($onehot0(hit));
  end
endmodule

// File: rtl/triple_write_seq.sv
module triple_write_seq
  import triple_write_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_own,
  input  logic abort,
  input  logic code_legal,
  input  sel_t code_sel,
  output sel_t sel_q,
  output sel_t pend_q,
  output cnt_t cnt_q,
  output logic commit_q
);
  localparam cnt_t LAST = cnt_t'(CONFIRM - 1);

  sel_t sel_d, pend_d;
  cnt_t cnt_d;
  logic commit_d;
  logic repeat_hit;

  assign repeat_hit = (cnt_q != '0) && (code_sel == pend_q);

  always_comb begin
    sel_d    = sel_q;
    pend_d   = pend_q;
    cnt_d    = cnt_q;
    commit_d = 1'b0;
    if (abort) begin
      cnt_d = '0;
    end else if (wr_own) begin
      if (!code_legal) begin
        cnt_d = '0;
      end else if (repeat_hit) begin
        if (cnt_q == LAST) begin
          sel_d    = code_sel;
          cnt_d    = '0;
          commit_d = 1'b1;
        end else begin
          cnt_d = cnt_q + cnt_t'(1);
        end
      end else begin
        cnt_d  = cnt_t'(1);
        pend_d = code_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= RESET_SEL;
      pend_q   <= '0;
      cnt_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      sel_q    <= sel_d;
      pend_q   <= pend_d;
      cnt_q    <= cnt_d;
      commit_q <= commit_d;
    end
  end

  assert_cnt_below_three_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != cnt_t'(3));
  assert_commit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> (cnt_q == '0));
  assert_sel_moves_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> commit_q);
  assert_commit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);
  assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (cnt_q == '0));
  assert_bad_code_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_own && !code_legal) |=> (cnt_q == '0) && $stable(sel_q));
endmodule

// File: rtl/triple_write_sel.sv
module triple_write_sel
  import triple_write_pkg::*;
#(
  parameter int unsigned ADDR_W         = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'h7F),
  parameter int unsigned HOLDOFF_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [SEL_W-1:0]  sel_id,
  output logic              sel_commit
);
  logic hit_addr, ready, wr_own, abort, code_legal, commit_q;
  sel_t code_sel, sel_q, pend_q;
  cnt_t cnt_q;
  logic [3:0] nibble;

  assign hit_addr = (bus_addr == REG_ADDR);
  assign wr_own   = bus_wr && hit_addr && ready;
  assign abort    = (bus_wr || bus_rd) && !hit_addr;

  triple_write_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_holdoff (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (ready)
  );

  triple_write_decode u_decode (
    .code  (bus_wdata),
    .legal (code_legal),
    .sel   (code_sel)
  );

  triple_write_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_own     (wr_own),
    .abort      (abort),
    .code_legal (code_legal),
    .code_sel   (code_sel),
    .sel_q      (sel_q),
    .pend_q     (pend_q),
    .cnt_q      (cnt_q),
    .commit_q   (commit_q)
  );

  always_comb begin
    nibble = '0;
    if (cnt_q != '0) nibble[pend_q] = 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && hit_addr) bus_rdata = {sel_q, cnt_q, nibble};
  end

  assign sel_id     = sel_q;
  assign sel_commit = commit_q;

  assert_holdoff_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_addr && !ready) |=> $stable(cnt_q) && $stable(sel_q));
  assert_own_read_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_addr && !bus_wr) |=> $stable(cnt_q) && $stable(pend_q));
  assert_nibble_form_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(nibble) && ((cnt_q == '0) == (nibble == '0)));
endmodule

// File: tb/triple_write_sel_bench.sv
module triple_write_sel_bench;
  localparam int HOLD = 16;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic bus_wr, bus_rd;
  logic [1:0] sel_id;
  logic sel_commit;
  int checks = 0;
  int errors = 0;

  logic [1:0] e_sel, e_pend, e_cnt;
  logic e_pulse;

  always #5 clk = ~clk;

  triple_write_sel #(.ADDR_W(8), .REG_ADDR(8'h7F), .HOLDOFF_CYCLES(HOLD)) u_triple_write_sel (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel_id(sel_id), .sel_commit(sel_commit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read();
    logic [3:0] nib;
    nib = (e_cnt == 0) ? 4'h0 : 4'(1 << e_pend);
    return {e_sel, e_cnt, nib};
  endfunction

  // spec model: legal bytes have equal one-hot nibbles; selection is bit index
  task automatic model(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d,
                       input bit live);
    bit legal;
    logic [1:0] s;
    legal = 0; s = 0;
    for (int i = 0; i < 4; i++)
      if (d == {4'(1 << i), 4'(1 << i)}) begin legal = 1; s = 2'(i); end
    e_pulse = 0;
    if (a != 8'h7F) begin
      if (w || r) e_cnt = 0;
    end else if (w && live) begin
      if (!legal) e_cnt = 0;
      else if (e_cnt != 0 && s == e_pend) begin
        if (e_cnt == 2) begin e_sel = s; e_cnt = 0; e_pulse = 1; end
        else e_cnt = e_cnt + 1;
      end else begin e_cnt = 1; e_pend = s; end
    end
  endtask

  task automatic op(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d,
                    input bit live, input string tag);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    #1;
    if (r && a != 8'h7F) chk(bus_rdata == 8'h00, "R10 foreign read data", bus_rdata, 0);
    model(w, r, a, d, live);
    @(posedge clk); @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    chk(sel_commit == e_pulse, {tag, " pulse"}, sel_commit, e_pulse);
    chk(sel_id == e_sel, {tag, " sel"}, sel_id, e_sel);
  endtask

  task automatic rd_own(input string tag);
    bus_rd = 1; bus_addr = 8'h7F;
    #1;
    chk(bus_rdata == exp_read(), tag, bus_rdata, exp_read());
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
    chk(sel_commit == 1'b0, "R5 pulse low after read", sel_commit, 0);
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    op(1, 0, 8'h7F, d, 1, tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    e_sel = 2'd1; e_pend = 0; e_cnt = 0; e_pulse = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(sel_id == 2'd1, "R1 reset sel", sel_id, 1);
    chk(sel_commit == 0, "R1 reset pulse", sel_commit, 0);
    rst_n = 1;
    // R9: writes inside hold-off are ignored
    op(1, 0, 8'h7F, 8'h88, 0, "R9 holdoff w1");
    op(1, 0, 8'h7F, 8'h88, 0, "R9 holdoff w2");
    op(1, 0, 8'h7F, 8'h88, 0, "R9 holdoff w3");
    rd_own("R1 R9 readback after holdoff writes");
    repeat (HOLD + 4) @(negedge clk);

    // R2 R3 R4 R5 R6: every byte value, three writes each
    for (int v = 0; v < 256; v++) begin
      wr(8'(v), "R2 R3 first write");
      rd_own("R3 R6 count after first");
      wr(8'(v), "R4 second write");
      rd_own("R4 count after second");
      wr(8'(v), "R5 third write");
      rd_own("R5 count after third");
    end

    // R7: foreign read aborts
    wr(8'h44, "R3 start");
    op(0, 1, 8'h10, 8'h00, 1, "R7 foreign read");
    rd_own("R7 count after foreign read");
    // R7: foreign write aborts
    wr(8'h44, "R3 start");
    wr(8'h44, "R4 repeat");
    op(1, 0, 8'h7E, 8'h44, 1, "R7 foreign write");
    rd_own("R7 count after foreign write");
    wr(8'h44, "R3 restart after abort");
    rd_own("R7 restarted at one");
    // R8: own reads mid-sequence do not abort
    wr(8'h44, "R4 after own read");
    rd_own("R8 own read mid sequence");
    rd_own("R8 second own read");
    wr(8'h44, "R5 commit after own reads");
    chk(sel_id == 2'd2, "R8 commit despite reads", sel_id, 2);
    // R3: alternating codes keep count at one
    wr(8'h11, "R3 alt a");
    wr(8'h22, "R3 alt b");
    wr(8'h11, "R3 alt c");
    rd_own("R3 alternating count");
    // R6: illegal mid-sequence
    wr(8'h11, "R4 alt repeat");
    wr(8'h12, "R6 illegal");
    rd_own("R6 cleared by illegal");
    wr(8'h88, "R5 a"); wr(8'h88, "R5 b"); wr(8'h88, "R5 c");
    chk(sel_id == 2'd3, "R5 final sel", sel_id, 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule